// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Per-Entry Page Size

This block translates 32-bit virtual addresses into physical addresses through a 64-entry, fully associative table that software fills and inspects by index. Every entry carries its own page size, chosen from eight sizes that grow by a factor of four, from 1 KB up to 16 MB. The tag compare therefore drops a different number of low virtual-page bits for each entry, and those bits pass straight through into the physical address. An entry matches only when it is valid and its address-space tag equals the current one. Its read, write and execute permission bits raise a fault on a hit that breaks them.

The block has two lookup ports, one for instruction fetch and one for data access. Each port can switch translation off on its own, and each sits behind a small private shadow buffer: four entries on the instruction side and eight on the data side. On a shadow hit the answer is ready one cycle after the request. On a shadow miss the port searches the main table in the next cycle and answers one cycle later. If that search hits, the entry is copied into the shadow buffer. Software has no view of the shadow buffers. Any software write to the main table empties both of them.

The main table is never refilled by hardware. The table walk and the choice of which entry to replace are left to software.

Top module: `xlat_tlb`

## Requirements
- R1: After reset every main entry reads back as zero and no response is pending. A lookup with translation on then returns hit=0, fault=0 and pa=0.
- R2: A write with `sw_we_i` stores `sw_wdata_i` at entry `sw_idx_i`, and `sw_rdata_o` shows the entry at `sw_idx_i` combinationally. The entry layout is: vpn [58:37] (virtual address bits 31:10), ppn [36:15], size code [14:12], address-space tag [11:4], valid [3], read permission [2], write permission [1], execute permission [0].
- R3: An entry with size code s covers 2^(10+2s) bytes and matches when va[31:10+2s] equals vpn[21:2s]. Vpn bits below that boundary are ignored. The physical address is ppn's bits above the boundary joined to va's bits below it.
- R4: When several main entries match during a main-table search, the entry with the lowest index supplies the result.
- R5: On a hit, an instruction lookup faults when execute is clear, a data read faults when read is clear, and a data write faults when write is clear. A miss returns hit=0, fault=0 and pa=0.
- R6: With a port's translation enable low, that port answers one cycle after the request with hit=1, fault=0 and pa equal to va. The shadow buffer is neither read nor filled.
- R7: A shadow hit answers one cycle after the request. A shadow miss answers two cycles after the request with the main-table result, and copies the entry into the shadow buffer only on a main-table hit.
- R8: The instruction shadow holds 4 entries and the data shadow 8. When a shadow buffer is full, a new fill replaces the entry that was filled earliest.
- R9: Any software write empties both shadow buffers, so the next translated lookup on either port takes the two-cycle path and returns the table's new contents.
- R10: A request raised in the cycle in which a port is searching the main table is ignored and produces no response.
- R11: An entry whose address-space tag differs from `asid_i` does not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| asid_i | input | 8 | Current address-space tag |
| i_en_i | input | 1 | Instruction translation enable |
| i_req_i | input | 1 | Instruction lookup request, one-cycle pulse |
| i_va_i | input | 32 | Instruction virtual address |
| i_vld_o | output | 1 | Instruction response valid |
| i_hit_o | output | 1 | Instruction translation hit |
| i_pa_o | output | 32 | Instruction physical address |
| i_fault_o | output | 1 | Instruction protection fault |
| d_en_i | input | 1 | Data translation enable |
| d_req_i | input | 1 | Data lookup request, one-cycle pulse |
| d_va_i | input | 32 | Data virtual address |
| d_wr_i | input | 1 | Data access is a write |
| d_vld_o | output | 1 | Data response valid |
| d_hit_o | output | 1 | Data translation hit |
| d_pa_o | output | 32 | Data physical address |
| d_fault_o | output | 1 | Data protection fault |
| sw_we_i | input | 1 | Software entry write strobe |
| sw_idx_i | input | 6 | Entry index for write and read |
| sw_wdata_i | input | 59 | Entry value to write |
| sw_rdata_o | output | 59 | Entry value at `sw_idx_i` |

## Verification
The bench puts one entry of every size code at addresses whose stored vpn has nonzero low bits. It then flips the highest offset bit, which must still hit, and the lowest tag bit, which must miss. A design that compared a fixed tag width, or did not pass the offset bits through, would return wrong addresses or false misses. Two overlapping entries check that the lower index wins. Rewriting that entry checks that the shadow buffers were flushed: a design that kept stale shadow entries would go on returning the old translation in one cycle. Lookup sequences longer than each shadow buffer check the earliest-filled eviction order and the one-cycle versus two-cycle timing. A request raised while a port is searching the main table checks that no stray second response appears.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

  localparam int VA_W   = 32;
  localparam int PG_MIN = 10;
  localparam int VPN_W  = VA_W - PG_MIN;
  localparam int SZ_W   = 3;
  localparam int ASID_W = 8;

  typedef struct packed {
    logic [VPN_W-1:0]  vpn;
    logic [VPN_W-1:0]  ppn;
    logic [SZ_W-1:0]   size;
    logic [ASID_W-1:0] asid;
    logic              valid;
    logic              rd;
    logic              wr;
    logic              ex;
  } xlat_ent_t;

  localparam int ENT_W = $bits(xlat_ent_t);

  typedef enum logic {P_IDLE, P_FILL} port_st_t;

  // Ones above the page boundary for a size code, within the vpn field.
  function automatic logic [VPN_W-1:0] vpn_keep(input logic [SZ_W-1:0] sz);
    logic [VPN_W-1:0] m;
    m = '1;
    m = m << {sz, 1'b0};
    return m;
  endfunction

  function automatic logic ent_match(input xlat_ent_t e,
                                     input logic [VA_W-1:0] va,
                                     input logic [ASID_W-1:0] asid);
    return e.valid && (e.asid == asid) &&
           (((e.vpn ^ va[VA_W-1:PG_MIN]) & vpn_keep(e.size)) == '0);
  endfunction

  function automatic logic [VA_W-1:0] form_pa(input xlat_ent_t e,
                                              input logic [VA_W-1:0] va);
    logic [VPN_W-1:0] m;
    m = vpn_keep(e.size);
    return {(e.ppn & m) | (va[VA_W-1:PG_MIN] & ~m), va[PG_MIN-1:0]};
  endfunction

  function automatic logic perm_fault(input xlat_ent_t e, input logic is_instr,
                                      input logic is_wr);
    if (is_instr) return !e.ex;
    return is_wr ? !e.wr : !e.rd;
  endfunction

endpackage

// File: rtl/xlat_search.sv
module xlat_search
  import xlat_pkg::*;
#(
  parameter int N = 64
) (
  input  xlat_ent_t [N-1:0]   ents_i,
  input  logic [VA_W-1:0]     va_i,
  input  logic [ASID_W-1:0]   asid_i,
  output logic                hit_o,
  output xlat_ent_t           ent_o
);

  // Scan from the top down so the lowest matching index is left standing.
  always_comb begin
    hit_o = 1'b0;
    ent_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ent_match(ents_i[i], va_i, asid_i)) begin
        hit_o = 1'b1;
        ent_o = ents_i[i];
      end
    end
  end

endmodule

// File: rtl/xlat_store.sv
module xlat_store
  import xlat_pkg::*;
#(
  parameter int N = 64,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  xlat_ent_t        wdata_i,
  output xlat_ent_t [N-1:0] ents_o,
  output xlat_ent_t        rdata_o
);

  xlat_ent_t [N-1:0] ents_q;
  xlat_ent_t [N-1:0] ents_d;

  always_comb begin
    ents_d = ents_q;
    if (we_i) ents_d[idx_i] = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ents_q <= '0;
    else if (we_i) ents_q <= ents_d;
  end

  assign ents_o  = ents_q;
  assign rdata_o = ents_q[idx_i];

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (ents_q[$past(idx_i)] == $past(wdata_i))); // R2

endmodule

// File: rtl/xlat_port.sv
module xlat_port
  import xlat_pkg::*;
#(
  parameter int   DEPTH    = 4,
  parameter logic IS_INSTR = 1'b1,
  localparam int  PTR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              req_i,
  input  logic [VA_W-1:0]   va_i,
  input  logic              wr_i,
  input  logic              inval_i,
  input  logic              main_hit_i,
  input  xlat_ent_t         main_ent_i,
  output logic [VA_W-1:0]   srch_va_o,
  output logic              vld_o,
  output logic              hit_o,
  output logic [VA_W-1:0]   pa_o,
  output logic              fault_o
);

  port_st_t               state_q, state_d;
  logic [VA_W-1:0]        va_q, va_d;
  logic                   wr_q, wr_d;
  logic                   va_en;
  logic [DEPTH-1:0]       sv_q, sv_d;
  logic [PTR_W-1:0]       ptr_q, ptr_d;
  logic                   sh_we;
  xlat_ent_t [DEPTH-1:0]  sh_q;
  xlat_ent_t [DEPTH-1:0]  sh_view;
  logic                   sh_hit;
  xlat_ent_t              sh_ent;
  logic                   vld_d, hit_d, fault_d;
  logic [VA_W-1:0]        pa_d;

  // Entries count only while their shadow slot is marked live.
  always_comb begin
    sh_view = sh_q;
    for (int i = 0; i < DEPTH; i++) sh_view[i].valid = sh_q[i].valid & sv_q[i];
  end

  xlat_search #(.N(DEPTH)) u_shsrch (
    .ents_i (sh_view),
    .va_i   (va_i),
    .asid_i (asid_i),
    .hit_o  (sh_hit),
    .ent_o  (sh_ent)
  );

  always_comb begin
    state_d = state_q;
    va_d    = va_q;
    wr_d    = wr_q;
    va_en   = 1'b0;
    sv_d    = sv_q;
    ptr_d   = ptr_q;
    sh_we   = 1'b0;
    vld_d   = 1'b0;
    hit_d   = 1'b0;
    pa_d    = '0;
    fault_d = 1'b0;
    unique case (state_q)
      P_IDLE: begin
        if (req_i) begin
          if (!en_i) begin
            vld_d = 1'b1;
            hit_d = 1'b1;
            pa_d  = va_i;
          end else if (sh_hit) begin
            vld_d   = 1'b1;
            hit_d   = 1'b1;
            pa_d    = form_pa(sh_ent, va_i);
            fault_d = perm_fault(sh_ent, IS_INSTR, wr_i);
          end else begin
            state_d = P_FILL;
            va_en   = 1'b1;
            va_d    = va_i;
            wr_d    = wr_i;
          end
        end
      end
      P_FILL: begin
        state_d = P_IDLE;
        vld_d   = 1'b1;
        hit_d   = main_hit_i;
        if (main_hit_i) begin
          pa_d    = form_pa(main_ent_i, va_q);
          fault_d = perm_fault(main_ent_i, IS_INSTR, wr_q);
          if (!inval_i) begin
            sh_we      = 1'b1;
            sv_d[ptr_q] = 1'b1;
            ptr_d      = (ptr_q == PTR_W'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
          end
        end
      end
      default: state_d = P_IDLE;
    endcase
    if (inval_i) sv_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= P_IDLE;
      va_q    <= '0;
      wr_q    <= 1'b0;
      sv_q    <= '0;
      ptr_q   <= '0;
      sh_q    <= '0;
      vld_o   <= 1'b0;
      hit_o   <= 1'b0;
      pa_o    <= '0;
      fault_o <= 1'b0;
    end else begin
      state_q <= state_d;
      if (va_en) begin
        va_q <= va_d;
        wr_q <= wr_d;
      end
      sv_q  <= sv_d;
      ptr_q <= ptr_d;
      if (sh_we) sh_q[ptr_q] <= main_ent_i;
      vld_o   <= vld_d;
      hit_o   <= hit_d;
      pa_o    <= pa_d;
      fault_o <= fault_d;
    end
  end

  assign srch_va_o = va_q;

  AST_FILL_ANSWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == P_FILL) |=> vld_o); // R7
  AST_FILL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == P_FILL) |=> (state_q == P_IDLE)); // R10
  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && fault_o) |-> hit_o); // R5
  AST_BYPASS_IDENT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == P_IDLE && req_i && !en_i) |=>
      (vld_o && hit_o && !fault_o && pa_o == $past(va_i))); // R6
  AST_INVAL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inval_i |=> (sv_q == '0)); // R9
  AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == P_FILL && main_hit_i) |=>
      (pa_o[PG_MIN-1:0] == $past(va_q[PG_MIN-1:0]))); // R3

endmodule

// File: rtl/xlat_tlb.sv
module xlat_tlb
  import xlat_pkg::*;
#(
  parameter int ENTRIES = 64,
  parameter int I_DEPTH = 4,
  parameter int D_DEPTH = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              i_en_i,
  input  logic              i_req_i,
  input  logic [VA_W-1:0]   i_va_i,
  output logic              i_vld_o,
  output logic              i_hit_o,
  output logic [VA_W-1:0]   i_pa_o,
  output logic              i_fault_o,
  input  logic              d_en_i,
  input  logic              d_req_i,
  input  logic [VA_W-1:0]   d_va_i,
  input  logic              d_wr_i,
  output logic              d_vld_o,
  output logic              d_hit_o,
  output logic [VA_W-1:0]   d_pa_o,
  output logic              d_fault_o,
  input  logic              sw_we_i,
  input  logic [IDX_W-1:0]  sw_idx_i,
  input  logic [ENT_W-1:0]  sw_wdata_i,
  output logic [ENT_W-1:0]  sw_rdata_o
);

  xlat_ent_t [ENTRIES-1:0] ents;
  xlat_ent_t               rdata;
  logic [VA_W-1:0]         i_srch_va, d_srch_va;
  logic                    i_mhit, d_mhit;
  xlat_ent_t               i_ment, d_ment;

  xlat_store #(.N(ENTRIES)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .we_i    (sw_we_i),
    .idx_i   (sw_idx_i),
    .wdata_i (xlat_ent_t'(sw_wdata_i)),
    .ents_o  (ents),
    .rdata_o (rdata)
  );

  assign sw_rdata_o = rdata;

  xlat_search #(.N(ENTRIES)) u_isrch (
    .ents_i (ents),
    .va_i   (i_srch_va),
    .asid_i (asid_i),
    .hit_o  (i_mhit),
    .ent_o  (i_ment)
  );

  xlat_search #(.N(ENTRIES)) u_dsrch (
    .ents_i (ents),
    .va_i   (d_srch_va),
    .asid_i (asid_i),
    .hit_o  (d_mhit),
    .ent_o  (d_ment)
  );

  xlat_port #(.DEPTH(I_DEPTH), .IS_INSTR(1'b1)) u_iport (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (i_en_i),
    .asid_i     (asid_i),
    .req_i      (i_req_i),
    .va_i       (i_va_i),
    .wr_i       (1'b0),
    .inval_i    (sw_we_i),
    .main_hit_i (i_mhit),
    .main_ent_i (i_ment),
    .srch_va_o  (i_srch_va),
    .vld_o      (i_vld_o),
    .hit_o      (i_hit_o),
    .pa_o       (i_pa_o),
    .fault_o    (i_fault_o)
  );

  xlat_port #(.DEPTH(D_DEPTH), .IS_INSTR(1'b0)) u_dport (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_i       (d_en_i),
    .asid_i     (asid_i),
    .req_i      (d_req_i),
    .va_i       (d_va_i),
    .wr_i       (d_wr_i),
    .inval_i    (sw_we_i),
    .main_hit_i (d_mhit),
    .main_ent_i (d_ment),
    .srch_va_o  (d_srch_va),
    .vld_o      (d_vld_o),
    .hit_o      (d_hit_o),
    .pa_o       (d_pa_o),
    .fault_o    (d_fault_o)
  );

  AST_NO_MISS_FAULT_D: assert property (@(posedge clk) disable iff (!rst_n)
    (d_vld_o && !d_hit_o) |-> (d_pa_o == '0 && !d_fault_o)); // R5

endmodule

// File: tb/sim_xlat_tlb.sv
module sim_xlat_tlb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  asid = 8'h05;
  logic        i_en = 1'b1, d_en = 1'b1;
  logic        i_req = 1'b0, d_req = 1'b0, d_wr = 1'b0;
  logic [31:0] i_va = '0, d_va = '0;
  logic        i_vld, i_hit, i_fault, d_vld, d_hit, d_fault;
  logic [31:0] i_pa, d_pa;
  logic        sw_we = 1'b0;
  logic [5:0]  sw_idx = '0;
  logic [58:0] sw_wdata = '0;
  logic [58:0] sw_rdata;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bit [58:0] mem [64];
  bit [58:0] iq [$];
  bit [58:0] dq [$];

  always #10 clk = ~clk;

  xlat_tlb u0 (
    .clk(clk), .rst_n(rst_n), .asid_i(asid),
    .i_en_i(i_en), .i_req_i(i_req), .i_va_i(i_va),
    .i_vld_o(i_vld), .i_hit_o(i_hit), .i_pa_o(i_pa), .i_fault_o(i_fault),
    .d_en_i(d_en), .d_req_i(d_req), .d_va_i(d_va), .d_wr_i(d_wr),
    .d_vld_o(d_vld), .d_hit_o(d_hit), .d_pa_o(d_pa), .d_fault_o(d_fault),
    .sw_we_i(sw_we), .sw_idx_i(sw_idx), .sw_wdata_i(sw_wdata), .sw_rdata_o(sw_rdata)
  );

  function automatic bit [58:0] mk(bit [21:0] vpn, bit [21:0] ppn, bit [2:0] sz,
                                   bit [7:0] id, bit v, bit r, bit w, bit x);
    return {vpn, ppn, sz, id, v, r, w, x};
  endfunction

  function automatic bit m_match(bit [58:0] e, bit [31:0] va, bit [7:0] id);
    int sh;
    bit [31:0] base;
    sh = 10 + 2 * int'(e[14:12]);
    base = {e[58:37], 10'b0};
    return e[3] && (e[11:4] == id) && ((va >> sh) == (base >> sh));
  endfunction

  function automatic bit [31:0] m_pa(bit [58:0] e, bit [31:0] va);
    int sh;
    bit [31:0] lo;
    sh = 10 + 2 * int'(e[14:12]);
    lo = (32'h1 << sh) - 32'h1;
    return ({e[36:15], 10'b0} & ~lo) | (va & lo);
  endfunction

  function automatic bit m_fault(bit [58:0] e, bit instr, bit wr);
    if (instr) return !e[0];
    return wr ? !e[1] : !e[2];
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  task automatic wr_ent(input int idx, input bit [58:0] e);
    @(negedge clk);
    sw_we = 1'b1; sw_idx = 6'(idx); sw_wdata = e;
    @(negedge clk);
    sw_we = 1'b0;
    mem[idx] = e;
    iq.delete();
    dq.delete();
  endtask

  task automatic look(input bit side, input logic [31:0] va, input bit wr,
                      input bit intr, input string rq);
    bit en, found, eh, ef;
    int lat;
    logic [31:0] ep;
    bit [58:0] e;
    en = side ? d_en : i_en;
    eh = 0; ef = 0; ep = '0; lat = 1; found = 0; e = '0;
    if (!en) begin
      eh = 1; ep = va;
    end else begin
      if (side) begin
        foreach (dq[k]) if (!found && m_match(dq[k], va, asid)) begin found = 1; e = dq[k]; end
      end else begin
        foreach (iq[k]) if (!found && m_match(iq[k], va, asid)) begin found = 1; e = iq[k]; end
      end
      if (!found) begin
        lat = 2;
        for (int k = 0; k < 64; k++)
          if (!found && m_match(mem[k], va, asid)) begin found = 1; e = mem[k]; end
        if (found) begin
          if (side) begin dq.push_back(e); if (dq.size() > 8) void'(dq.pop_front()); end
          else begin iq.push_back(e); if (iq.size() > 4) void'(iq.pop_front()); end
        end
      end
      if (found) begin eh = 1; ep = m_pa(e, va); ef = m_fault(e, !side, wr); end
    end
    @(negedge clk);
    if (side) begin d_req = 1; d_va = va; d_wr = wr; end
    else begin i_req = 1; i_va = va; end
    @(negedge clk);
    d_req = 0; i_req = 0;
    if (lat == 2) begin
      chk((side ? d_vld : i_vld) == 1'b0, "R7", "no early response", side ? d_vld : i_vld, 0);
      if (intr) begin
        if (side) begin d_req = 1; d_va = va ^ 32'h0F00_0000; end
        else begin i_req = 1; i_va = va ^ 32'h0F00_0000; end
      end
      @(negedge clk);
      d_req = 0; i_req = 0;
    end
    chk((side ? d_vld : i_vld) == 1'b1, rq, "response valid", side ? d_vld : i_vld, 1);
    chk((side ? d_hit : i_hit) == eh, rq, "hit", side ? d_hit : i_hit, eh);
    chk((side ? d_pa : i_pa) == ep, rq, "pa", side ? d_pa : i_pa, ep);
    chk((side ? d_fault : i_fault) == ef, rq, "fault", side ? d_fault : i_fault, ef);
    if (intr) begin
      @(negedge clk);
      chk((side ? d_vld : i_vld) == 1'b0, "R10", "ignored request answered",
          side ? d_vld : i_vld, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] vs;
    foreach (mem[k]) mem[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(d_vld == 0 && i_vld == 0, "R1", "vld after reset", {i_vld, d_vld}, 0);
    sw_idx = 6'd17; #1;
    chk(sw_rdata == '0, "R1", "entry after reset", sw_rdata, 0);
    look(1, 32'h0001_27AB, 0, 0, "R1");

    // R2: write and read back by index
    wr_ent(0, mk(22'h49, 22'h3_0001, 3'd0, 8'h05, 1, 1, 0, 0));
    wr_ent(1, mk(22'h80, 22'h0_4567, 3'd1, 8'h05, 1, 0, 0, 1));
    sw_idx = 6'd0; #1;
    chk(sw_rdata == mem[0], "R2", "readback idx0", sw_rdata, mem[0]);
    sw_idx = 6'd1; #1;
    chk(sw_rdata == mem[1], "R2", "readback idx1", sw_rdata, mem[1]);

    // R7: miss then shadow hit; R5: permission faults
    look(1, 32'h0001_27AB, 0, 0, "R7");
    look(1, 32'h0001_2400, 0, 0, "R7");
    look(1, 32'h0001_27FF, 1, 0, "R5");
    look(0, 32'h0001_2410, 0, 0, "R5");
    look(0, 32'h0002_0ABC, 0, 0, "R5");
    look(1, 32'h0002_0ABC, 0, 0, "R5");
    look(1, 32'h0003_0000, 0, 1, "R10");

    // R3: every size code, masked vpn bits, offset pass-through
    for (int s = 0; s < 8; s++) begin
      vs = (32'(s + 1) << 28) | 32'h0356_789A;
      wr_ent(10 + s, mk(vs[31:10], 22'h2A5A5 ^ 22'(s), 3'(s), 8'h05, 1, 1, 1, 1));
    end
    for (int s = 0; s < 8; s++) begin
      vs = (32'(s + 1) << 28) | 32'h0356_789A;
      look(1, vs, 0, 0, "R3");
      look(1, vs ^ (32'h1 << (9 + 2 * s)), 1, 0, "R3");
      look(1, vs ^ (32'h1 << (10 + 2 * s)), 0, 0, "R3");
    end
    // R8: data shadow capacity and eviction order (10 distinct pages)
    look(1, 32'h0001_2400, 0, 0, "R8");
    look(1, 32'h0002_0000, 0, 0, "R8");
    for (int s = 0; s < 8; s++) look(1, (32'(s + 1) << 28) | 32'h0356_789A, 0, 0, "R8");
    look(1, 32'h0001_2400, 0, 0, "R8");
    look(1, 32'h8356_789A, 0, 0, "R8");
    // R8: instruction shadow capacity
    for (int s = 0; s < 6; s++) look(0, (32'(s + 1) << 28) | 32'h0356_789A, 0, 0, "R8");
    look(0, 32'h1356_789A, 0, 0, "R8");
    look(0, 32'h6356_789A, 0, 0, "R8");
    look(0, 32'h3356_789A, 0, 0, "R8");

    // R4: overlapping entries, lowest index wins
    wr_ent(40, mk(22'h28_4000, 22'h1_1111, 3'd7, 8'h05, 1, 1, 1, 0));
    wr_ent(35, mk(22'h28_48D0, 22'h2_2222, 3'd2, 8'h05, 1, 1, 0, 0));
    look(1, 32'hA123_4567, 0, 0, "R4");
    look(1, 32'hA123_4567, 1, 0, "R4");
    // R9: rewrite empties shadows; result follows the table
    look(0, 32'h1356_789A, 0, 0, "R9");
    wr_ent(35, mk(22'h28_48D0, 22'h2_2222, 3'd2, 8'h05, 0, 1, 0, 0));
    look(1, 32'hA123_4567, 0, 0, "R9");
    look(0, 32'h1356_789A, 0, 0, "R9");

    // R11: other address-space tag misses
    asid = 8'h06;
    look(1, 32'h1356_789A, 0, 0, "R11");
    look(0, 32'h2356_789A, 0, 0, "R11");
    asid = 8'h05;

    // R6: translation disabled per port
    i_en = 1'b0;
    look(0, 32'h1234_5678, 0, 0, "R6");
    look(1, 32'h0001_2400, 1, 0, "R6");
    i_en = 1'b1;
    d_en = 1'b0;
    look(1, 32'hDEAD_BEEF, 1, 0, "R6");
    d_en = 1'b1;
    look(1, 32'h4356_789A, 0, 0, "R6");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule